// File: doc/BRIEF.md
# Signed Four-Bit Adder with Sign-Magnitude Decimal Output

This block adds two 4-bit two's complement numbers and gives the sum in a form a two-digit decimal readout can show directly. The outputs are a sign flag, a one-bit tens digit, a 4-bit BCD ones digit and an active-high seven-segment pattern for each digit. The block is purely combinational and has no clock or reset.

The sum is formed at five bits, with both operands widened by sign extension. The block then builds two BCD readings from the lower four bits of the sum. One reading treats those bits as a non-negative value. The other treats them as the low part of a negative value, whose magnitude is sixteen minus those bits. The sum's sign bit picks one of the two readings. The magnitude never exceeds 16, so the tens digit needs only one bit. The parity of the magnitude always matches the parity of the sum, so the ones digit's weight-1 bit is taken straight from the sum's least significant bit.

Top module: `sbcd_adder`

## Requirements
- R1: For any operands a and b in -8..7, the displayed value, (neg_o ? -1 : 1) * (10*tens_o + ones_o), equals a + b. The sum spans -16 to +14.
- R2: The sum is formed from sign-extended operands and never from the adder's carry-out. An operand of -8 (4'b1000) added to 0 gives neg_o=1, tens_o=0, ones_o=8.
- R3: neg_o is 1 exactly when the sum is negative, that is, when bit 4 of the 5-bit sum is set.
- R4: tens_o is 1 exactly when the magnitude is 10 or more. ones_o is the magnitude modulo 10 in plain BCD, always in 0..9.
- R5: ones_o[0] equals the least significant bit of the 5-bit sum (bit 0 of op_a XOR bit 0 of op_b).
- R6: A sum of -16 (both operands 4'b1000) gives neg_o=1, tens_o=1, ones_o=6.
- R7: A zero sum never shows as negative: neg_o=0, tens_o=0, ones_o=0.
- R8: seg_ones_o encodes ones_o active-high with bit 0 = segment a through bit 6 = segment g. The patterns for 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R9: seg_tens_o shows the tens digit with the same encoding: 0x3F when tens_o=0 and 0x06 when tens_o=1.
- R10: The largest sum, 7 + 7, gives neg_o=0, tens_o=1, ones_o=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | First operand, two's complement |
| op_b | input | 4 | Second operand, two's complement |
| neg_o | output | 1 | High when the sum is negative |
| tens_o | output | 1 | Tens digit of the magnitude (0 or 1) |
| ones_o | output | 4 | Ones digit of the magnitude, BCD |
| seg_tens_o | output | 7 | Tens digit segments, bit 0 = a, active-high |
| seg_ones_o | output | 7 | Ones digit segments, bit 0 = a, active-high |

## Verification
The in-line assertions assume the operands are fully driven 4-bit values. Each one checks a relation that must hold for every operand pair, for example that two negative operands give a set sign bit or that the ones digit stays within 0 to 9. Because the block has no state, the stimulus covers the whole input space. All 256 operand pairs are applied one per clock, and the outputs are compared only after the inputs have settled half a period. The extreme sums (-16, +14, zero and the -8 + 0 case) are then repeated as named cases.

// File: rtl/sbcd_pkg.sv
// Shared widths and types for the signed adder with decimal output.
// Assumes 4-bit operands, which keeps the tens digit to a single bit.
package sbcd_pkg;
    localparam int OP_W    = 4;
    localparam int SUM_W   = OP_W + 1;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    // One BCD reading of a magnitude; the weight-1 ones bit is carried separately
    typedef struct packed {
        logic       tens;
        logic [2:0] ones_hi;
    } bcd_side_t;
endpackage

// File: rtl/sbcd_sum.sv
// Five-bit signed sum of two sign-extended operands.
// Assumes OPW-bit two's complement inputs; the adder's carry-out is never used.
module sbcd_sum #(
    parameter int OPW  = 4,
    localparam int SW  = OPW + 1
) (
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    output logic [SW-1:0]  sum_o
);
    logic [SW-1:0] a_ext;
    logic [SW-1:0] b_ext;

    // Widen both operands by copying their sign bit, then add at full width
    always_comb begin
        a_ext = {a_i[OPW-1], a_i};
        b_ext = {b_i[OPW-1], b_i};
        sum_o = a_ext + b_ext;
    end

    // Sign of the sum must follow the operands when both share a sign
    always_comb begin
        if (a_i[OPW-1] && b_i[OPW-1])
            a_r2_negneg: assert (sum_o[SW-1]) else $error("R2: two negatives gave non-negative sum");
        if (!a_i[OPW-1] && !b_i[OPW-1])
            a_r3_pospos: assert (!sum_o[SW-1]) else $error("R3: two non-negatives gave negative sum");
    end
endmodule

// File: rtl/sbcd_half.sv
// One BCD reading of the lower sum bits: non-negative view or negative view.
// NEG_SIDE=0 uses the bits as the magnitude; NEG_SIDE=1 uses 2**OPW minus the bits.
// Assumes OPW=4, so magnitudes stay within 0..16 and the tens digit is one bit.
module sbcd_half
    import sbcd_pkg::*;
#(
    parameter int OPW      = 4,
    parameter bit NEG_SIDE = 1'b0,
    localparam int MW      = OPW + 1
) (
    input  logic [OPW-1:0] low_i,
    output bcd_side_t      bcd_o
);
    logic [MW-1:0]  mag;
    logic [OPW-1:0] half_mag;
    logic [OPW-1:0] half_ones;
    logic           ge_ten;

    // Form the magnitude for the chosen view
    generate
        if (NEG_SIDE) begin : g_neg
            always_comb mag = MW'(1 << OPW) - {1'b0, low_i};
        end else begin : g_pos
            always_comb mag = {1'b0, low_i};
        end
    endgenerate

    // Work on magnitude/2: ten becomes five and the weight-1 bit drops out
    always_comb begin
        half_mag  = mag[MW-1:1];
        ge_ten    = (half_mag >= OPW'(5));
        half_ones = ge_ten ? (half_mag - OPW'(5)) : half_mag;
        bcd_o.tens    = ge_ten;
        bcd_o.ones_hi = half_ones[2:0];
    end

    // Halved ones digit must fit in three bits, and parity must survive the view
    always_comb begin
        a_r4_ones_fit: assert (half_ones[OPW-1:3] == '0) else $error("R4: ones digit above 9");
        a_r5_parity: assert (mag[0] == low_i[0]) else $error("R5: magnitude parity differs from sum");
    end
endmodule

// File: rtl/sbcd_seg.sv
// BCD digit to active-high seven-segment pattern, bit 0 = segment a.
// Assumes a BCD digit; codes 10..15 give a blank pattern.
module sbcd_seg
    import sbcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [SEG_W-1:0]   seg_o
);
    // Look up the lit segments for each decimal digit
    always_comb begin
        case (digit_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7D;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h6F;
            default: seg_o = 7'h00;
        endcase
    end

    // Every valid digit lights at least two segments
    always_comb begin
        if (digit_i <= DIGIT_W'(9))
            a_r8_lit: assert ($countones(seg_o) >= 2) else $error("R8: valid digit left nearly dark");
    end
endmodule

// File: rtl/sbcd_adder.sv
// Top: signed 4-bit adder with sign flag, two BCD digits and segment patterns.
// Builds a non-negative and a negative BCD reading of the low sum bits and
// picks one on the sum's sign bit. Purely combinational; no clock or reset.
module sbcd_adder
    import sbcd_pkg::*;
(
    input  logic [3:0] op_a,
    input  logic [3:0] op_b,
    output logic       neg_o,
    output logic       tens_o,
    output logic [3:0] ones_o,
    output logic [6:0] seg_tens_o,
    output logic [6:0] seg_ones_o
);
    logic [SUM_W-1:0] sum;
    bcd_side_t        pos_bcd;
    bcd_side_t        neg_bcd;
    bcd_side_t        pick;

    sbcd_sum #(.OPW(OP_W)) u_sum (
        .a_i   (op_a),
        .b_i   (op_b),
        .sum_o (sum)
    );

    sbcd_half #(.OPW(OP_W), .NEG_SIDE(1'b0)) u_pos (
        .low_i (sum[OP_W-1:0]),
        .bcd_o (pos_bcd)
    );

    sbcd_half #(.OPW(OP_W), .NEG_SIDE(1'b1)) u_neg (
        .low_i (sum[OP_W-1:0]),
        .bcd_o (neg_bcd)
    );

    // Choose the reading on the sign bit and attach the weight-1 bit
    always_comb begin
        pick   = sum[SUM_W-1] ? neg_bcd : pos_bcd;
        neg_o  = sum[SUM_W-1];
        tens_o = pick.tens;
        ones_o = {pick.ones_hi, sum[0]};
    end

    sbcd_seg u_seg_tens (
        .digit_i ({3'b000, tens_o}),
        .seg_o   (seg_tens_o)
    );

    sbcd_seg u_seg_ones (
        .digit_i (ones_o),
        .seg_o   (seg_ones_o)
    );

    // Range of the displayed result: no negative zero, positive side tops out at 14
    always_comb begin
        if (neg_o)
            a_r7_no_neg_zero: assert (tens_o || (ones_o != 4'd0)) else $error("R7: negative zero shown");
        if (!neg_o)
            a_r10_pos_max: assert (!(tens_o && (ones_o > 4'd4))) else $error("R10: positive result above 14");
        a_r4_bcd_digit: assert (ones_o <= 4'd9) else $error("R4: ones digit not BCD");
    end
endmodule

// File: tb/sim_sbcd_adder.sv
// Exhaustive bench for sbcd_adder: expected values come from integer arithmetic.
module sim_sbcd_adder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_a = 4'd0;
    logic [3:0] op_b = 4'd0;
    logic       neg_o;
    logic       tens_o;
    logic [3:0] ones_o;
    logic [6:0] seg_tens_o;
    logic [6:0] seg_ones_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sbcd_adder u0 (
        .op_a       (op_a),
        .op_b       (op_b),
        .neg_o      (neg_o),
        .tens_o     (tens_o),
        .ones_o     (ones_o),
        .seg_tens_o (seg_tens_o),
        .seg_ones_o (seg_ones_o)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d act=%0d exp=%0d", req, $signed(op_a), $signed(op_b), act, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        @(posedge clk);
        op_a = 4'(a);
        op_b = 4'(b);
        @(negedge clk);
    endtask

    task automatic check_all(input int a, input int b);
        int s, mag, shown;
        s     = a + b;
        mag   = (s < 0) ? -s : s;
        shown = (neg_o ? -1 : 1) * (10 * int'(tens_o) + int'(ones_o));
        check(shown == s,                         "R1 value",     shown,           s);
        check(neg_o == (s < 0),                   "R3 sign",      int'(neg_o),     int'(s < 0));
        check(tens_o == (mag >= 10),              "R4 tens",      int'(tens_o),    int'(mag >= 10));
        check(int'(ones_o) == mag % 10,           "R4 ones",      int'(ones_o),    mag % 10);
        check(ones_o[0] == (op_a[0] ^ op_b[0]),   "R5 lsb",       int'(ones_o[0]), int'(op_a[0] ^ op_b[0]));
        check(seg_ones_o == exp_seg(mag % 10),    "R8 seg ones",  int'(seg_ones_o), int'(exp_seg(mag % 10)));
        check(seg_tens_o == exp_seg(mag / 10),    "R9 seg tens",  int'(seg_tens_o), int'(exp_seg(mag / 10)));
    endtask

    initial begin : main
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Idle state with zero operands
        apply(0, 0);
        check(!neg_o && !tens_o && ones_o == 4'd0, "R7 zero idle", int'(ones_o), 0);
        check(seg_tens_o == 7'h3F && seg_ones_o == 7'h3F, "R9 zero segs", int'(seg_ones_o), 'h3F);

        // Every operand pair
        for (int ia = -8; ia < 8; ia++) begin
            for (int ib = -8; ib < 8; ib++) begin
                apply(ia, ib);
                check_all(ia, ib);
            end
        end

        // R2: -8 + 0 must read as minus eight
        apply(-8, 0);
        check(neg_o && !tens_o && ones_o == 4'd8, "R2 -8+0", int'(ones_o), 8);
        // R6: -16 reads as sign, 1, 6
        apply(-8, -8);
        check(neg_o && tens_o && ones_o == 4'd6, "R6 -16", int'(ones_o), 6);
        // R10: largest positive sum
        apply(7, 7);
        check(!neg_o && tens_o && ones_o == 4'd4, "R10 +14", int'(ones_o), 4);
        // R7: cancelling operands give plain zero
        apply(5, -5);
        check(!neg_o && !tens_o && ones_o == 4'd0, "R7 5-5", int'(neg_o), 0);
        // R9: tens pattern for one ten
        apply(-8, -3);
        check(seg_tens_o == 7'h06, "R9 tens one", int'(seg_tens_o), 'h06);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule